// File: doc/BRIEF.md
# Paged Register Bus Interface

This block is the host-facing register front end of a 48-line digital I/O device. A byte-wide host bus reaches sixteen byte locations through a 4-bit address with separate read and write strobes. Six byte registers drive the I/O lines, one register per group of eight lines. Each line behaves like an open-drain output. A 1 in the register pulls the line low. A 0 lets the line float high, so an outside device can pull it low, and in that state the line serves as an input. Reads of a port return the real pin levels, inverted, so a 1 means the line is low.

A shared control byte has two jobs. Its two top bits choose a page, and that page decides what the three locations just above the control byte reach: polarity bytes, enable bytes, or the edge-detect block's event-ID bytes. Its six low bits each write-protect one port. The polarity and enable bytes are stored here and driven out to the edge-detect block. The event-ID bytes live in that block and are reached through a sideband of read and write strobes plus a byte index. A 3-bit pending summary from the edge-detect block can be read at its own location.

Top module: `hdio_regbank`

## Requirements
- R1: After reset, every port byte, the control byte (so page 0 with no port locked), all polarity bytes and all enable bytes are 0x00, `pin_pull_low` is all zero and `bus_rdata` is 0x00.
- R2: A write of D to offset k (k = 0 to 5) of an unlocked port sets `pin_pull_low[8k+7:8k]` to D. Bit b set to 1 pulls line 8k+b low, and 0 releases it.
- R3: A read of offset k (0 to 5) returns the bitwise inverse of `pin_in[8k+7:8k]` as sampled at the read edge. This is 1 for every line that is low, whether the port drives it low or something outside does.
- R4: Offset 0x7 is the control byte. Bits 7:6 hold the page and bit n (n = 0 to 5) locks port n. A write to a locked port leaves that port unchanged. A read of a locked port still returns its pin levels. Clearing the bit unlocks the port.
- R5: A read of offset 0x6 returns {5'b0, `pend_in`}. Writes to 0x6 change nothing.
- R6: On page 1, writes to offsets 0x8 to 0xA load polarity byte i = offset-8 (`edge_pol[8i+7:8i]`). On page 2 they load enable byte i (`edge_en[8i+7:8i]`). Reads of these locations on pages 1 and 2 return 0x00.
- R7: On page 3, an access to offset 0x8+i pulses `id_wr` (for a write) or `id_rd` (for a read) in the same cycle, with `id_sel` = i and `id_wdata` = the bus data. A read returns `id_rdata`. On any other page both strobes stay low.
- R8: A read of offset 0x7, of 0x8 to 0xA on page 0, or of 0xB to 0xF returns 0x00. Writes to 0x8 to 0xA on page 0, and writes to 0xB to 0xF, change no register.
- R9: `bus_rdata` is registered. It updates at the clock edge on which `bus_rd` is high and holds its value while `bus_rd` is low. Writes take effect at the clock edge on which `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset inside the 16-byte window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Sampled levels of the I/O lines |
| pin_pull_low | output | 48 | 1 pulls the matching line low |
| pend_in | input | 3 | Pending-event summary from the edge-detect block |
| edge_pol | output | 24 | Polarity bytes for the edge-detect block |
| edge_en | output | 24 | Enable bytes for the edge-detect block |
| id_wr | output | 1 | Sideband write strobe to the event-ID bytes |
| id_rd | output | 1 | Sideband read strobe to the event-ID bytes |
| id_sel | output | 2 | Event-ID byte index |
| id_wdata | output | 8 | Event-ID write data |
| id_rdata | input | 8 | Event-ID read data, returned combinationally |

## Verification
The assertions assume the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume that `pin_in`, `pend_in` and `id_rdata` are stable around the sampling edge. The bench drives every strobe, address and data value at the falling clock edge and keeps it for exactly one full cycle. It issues only a read or only a write per access. It derives `pin_in` from the block's own pull-low outputs combined with an external pull-down mask, which it changes only between accesses. A behavioural stand-in for the event-ID store answers the sideband read at once and takes writes at the clock edge.

// File: rtl/hdio_pkg.sv
package hdio_pkg;
    localparam int PORT_W     = 8;
    localparam int PORT_CNT   = 6;
    localparam int BANK_CNT   = 3;
    localparam int ADDR_W     = 4;
    localparam int BANK_START = 8;

    typedef enum logic [1:0] {
        PG_PLAIN = 2'd0,
        PG_POL   = 2'd1,
        PG_ENAB  = 2'd2,
        PG_ID    = 2'd3
    } page_e;
endpackage

// File: rtl/hdio_addr_dec.sv
module hdio_addr_dec #(
    parameter int AW        = hdio_pkg::ADDR_W,
    parameter int NPORTS    = hdio_pkg::PORT_CNT,
    parameter int NBANK     = hdio_pkg::BANK_CNT,
    parameter int BANK_BASE = hdio_pkg::BANK_START,
    localparam int PIW      = $clog2(NPORTS),
    localparam int BIW      = $clog2(NBANK)
) (
    input  logic [AW-1:0]  addr,
    output logic           hit_port,
    output logic [PIW-1:0] port_sel,
    output logic           hit_pend,
    output logic           hit_ctl,
    output logic           hit_bank,
    output logic [BIW-1:0] bank_sel
);
    always_comb begin
        hit_port = int'(addr) < NPORTS;
        port_sel = PIW'(addr);
        hit_pend = int'(addr) == NPORTS;
        hit_ctl  = int'(addr) == NPORTS + 1;
        hit_bank = (int'(addr) >= BANK_BASE) && (int'(addr) < BANK_BASE + NBANK);
        bank_sel = BIW'(addr - AW'(BANK_BASE));
    end
endmodule

// File: rtl/hdio_port_file.sv
module hdio_port_file #(
    parameter int PW       = hdio_pkg::PORT_W,
    parameter int NPORTS   = hdio_pkg::PORT_CNT,
    localparam int PIW     = $clog2(NPORTS),
    localparam int NL      = NPORTS * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PIW-1:0]    sel,
    input  logic [PW-1:0]     wdata,
    input  logic [NPORTS-1:0] lock,
    output logic [NL-1:0]     drive
);
    typedef struct packed {
        logic [NPORTS-1:0][PW-1:0] port;
    } pf_state_t;

    pf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPORTS; i++) begin
            if (wr_en && sel == PIW'(i) && !lock[i]) begin
                st_d.port[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_drive
        assign drive[g*PW +: PW] = st_q.port[g];
    end
endmodule

// File: rtl/hdio_page_file.sv
module hdio_page_file #(
    parameter int PW       = hdio_pkg::PORT_W,
    parameter int NPORTS   = hdio_pkg::PORT_CNT,
    parameter int NBANK    = hdio_pkg::BANK_CNT,
    localparam int BIW     = $clog2(NBANK),
    localparam int BW      = NBANK * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_bank,
    input  logic              rd_bank,
    input  logic [BIW-1:0]    sel,
    input  logic [PW-1:0]     wdata,
    output logic [NPORTS-1:0] lock,
    output logic [BW-1:0]     pol,
    output logic [BW-1:0]     en,
    output logic              id_wr,
    output logic              id_rd
);
    import hdio_pkg::*;

    typedef struct packed {
        logic [PW-1:0]            ctl;
        logic [NBANK-1:0][PW-1:0] pol;
        logic [NBANK-1:0][PW-1:0] en;
    } pg_state_t;

    pg_state_t st_d, st_q;
    page_e     page;

    assign page = page_e'(st_q.ctl[PW-1 -: 2]);

    always_comb begin
        st_d = st_q;
        if (wr_ctl) st_d.ctl = wdata;
        for (int i = 0; i < NBANK; i++) begin
            if (wr_bank && sel == BIW'(i)) begin
                if (page == PG_POL)  st_d.pol[i] = wdata;
                if (page == PG_ENAB) st_d.en[i]  = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock  = st_q.ctl[NPORTS-1:0];
    assign id_wr = wr_bank && (page == PG_ID);
    assign id_rd = rd_bank && (page == PG_ID);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank_out
        assign pol[g*PW +: PW] = st_q.pol[g];
        assign en[g*PW +: PW]  = st_q.en[g];
    end
endmodule

// File: rtl/hdio_regbank.sv
module hdio_regbank #(
    parameter int AW        = hdio_pkg::ADDR_W,
    parameter int PW        = hdio_pkg::PORT_W,
    parameter int NPORTS    = hdio_pkg::PORT_CNT,
    parameter int NBANK     = hdio_pkg::BANK_CNT,
    parameter int BANK_BASE = hdio_pkg::BANK_START,
    localparam int PIW      = $clog2(NPORTS),
    localparam int BIW      = $clog2(NBANK),
    localparam int NL       = NPORTS * PW,
    localparam int BW       = NBANK * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [PW-1:0]    bus_wdata,
    output logic [PW-1:0]    bus_rdata,
    input  logic [NL-1:0]    pin_in,
    output logic [NL-1:0]    pin_pull_low,
    input  logic [NBANK-1:0] pend_in,
    output logic [BW-1:0]    edge_pol,
    output logic [BW-1:0]    edge_en,
    output logic             id_wr,
    output logic             id_rd,
    output logic [BIW-1:0]   id_sel,
    output logic [PW-1:0]    id_wdata,
    input  logic [PW-1:0]    id_rdata
);
    logic              hit_port, hit_pend, hit_ctl, hit_bank;
    logic [PIW-1:0]    port_sel;
    logic [BIW-1:0]    bank_sel;
    logic [NPORTS-1:0] port_lock;

    hdio_addr_dec #(
        .AW(AW), .NPORTS(NPORTS), .NBANK(NBANK), .BANK_BASE(BANK_BASE)
    ) u_dec (
        .addr     (bus_addr),
        .hit_port (hit_port),
        .port_sel (port_sel),
        .hit_pend (hit_pend),
        .hit_ctl  (hit_ctl),
        .hit_bank (hit_bank),
        .bank_sel (bank_sel)
    );

    hdio_port_file #(.PW(PW), .NPORTS(NPORTS)) u_ports (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && hit_port),
        .sel   (port_sel),
        .wdata (bus_wdata),
        .lock  (port_lock),
        .drive (pin_pull_low)
    );

    hdio_page_file #(.PW(PW), .NPORTS(NPORTS), .NBANK(NBANK)) u_pages (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (bus_wr && hit_ctl),
        .wr_bank (bus_wr && hit_bank),
        .rd_bank (bus_rd && hit_bank),
        .sel     (bank_sel),
        .wdata   (bus_wdata),
        .lock    (port_lock),
        .pol     (edge_pol),
        .en      (edge_en),
        .id_wr   (id_wr),
        .id_rd   (id_rd)
    );

    assign id_sel   = bank_sel;
    assign id_wdata = bus_wdata;

    typedef struct packed {
        logic [PW-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            rd_d.data = '0;
            if (hit_port) begin
                for (int i = 0; i < NPORTS; i++) begin
                    if (port_sel == PIW'(i)) rd_d.data = ~pin_in[i*PW +: PW];
                end
            end else if (hit_pend) begin
                rd_d.data = PW'(pend_in);
            end else if (id_rd) begin
                rd_d.data = id_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.data;
endmodule

// File: rtl/hdio_regbank_chk.sv
module hdio_regbank_chk #(
    parameter int AW        = 4,
    parameter int PW        = 8,
    parameter int NPORTS    = 6,
    parameter int NBANK     = 3,
    parameter int BANK_BASE = 8,
    localparam int NL       = NPORTS * PW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     addr,
    input logic              rd,
    input logic              wr,
    input logic [NL-1:0]     pin_in,
    input logic [NL-1:0]     drive,
    input logic [PW-1:0]     rdata,
    input logic [NPORTS-1:0] lock,
    input logic              id_wr,
    input logic              id_rd
);
    logic [PW-1:0] pin_inv;
    logic          prot_hit;
    logic          in_bank;

    always_comb begin
        pin_inv  = '0;
        prot_hit = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (addr == AW'(i)) begin
                pin_inv  = ~pin_in[i*PW +: PW];
                prot_hit = lock[i];
            end
        end
        in_bank = (int'(addr) >= BANK_BASE) && (int'(addr) < BANK_BASE + NBANK);
    end

    // R4
    locked_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && prot_hit) |=> (drive == $past(drive)));

    // R3
    port_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && int'(addr) < NPORTS) |=> (rdata == $past(pin_inv)));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R8
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && int'(addr) == NPORTS + 1) |=> (rdata == '0));

    // R7
    id_wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_wr |-> (wr && in_bank));

    // R7
    id_rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_rd |-> (rd && in_bank));
endmodule

bind hdio_regbank hdio_regbank_chk #(
    .AW(AW), .PW(PW), .NPORTS(NPORTS), .NBANK(NBANK), .BANK_BASE(BANK_BASE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .pin_in (pin_in),
    .drive  (pin_pull_low),
    .rdata  (bus_rdata),
    .lock   (port_lock),
    .id_wr  (id_wr),
    .id_rd  (id_rd)
);

// File: tb/tb_hdio_regbank.sv
`timescale 1ns/1ps
module tb_hdio_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] pin_in, pull_low;
    logic [47:0] ext_pull = '0;
    logic [2:0]  pend = '0;
    logic [23:0] pol, en;
    logic        id_wr, id_rd;
    logic [1:0]  id_sel;
    logic [7:0]  id_wdata, id_rdata;
    logic [7:0]  id_mem [3];

    int nchecks = 0;
    int nerrors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign pin_in   = ~(pull_low | ext_pull);
    assign id_rdata = (id_sel < 2'd3) ? id_mem[id_sel] : 8'h00;

    hdio_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in), .pin_pull_low(pull_low),
        .pend_in(pend), .edge_pol(pol), .edge_en(en), .id_wr(id_wr), .id_rd(id_rd),
        .id_sel(id_sel), .id_wdata(id_wdata), .id_rdata(id_rdata)
    );

    // stand-in for the event-ID store of the edge-detect block
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) id_mem[i] <= 8'h00;
        end else if (id_wr && id_sel < 2'd3) begin
            id_mem[id_sel] <= id_wdata;
        end
    end

    // behavioural reference model
    logic [7:0] m_port [6];
    logic [7:0] m_pol [3];
    logic [7:0] m_en [3];
    logic [7:0] m_ctl, m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_port[i] = 8'h00;
            for (int i = 0; i < 3; i++) begin m_pol[i] = 8'h00; m_en[i] = 8'h00; end
            m_ctl = 8'h00;
            m_rdata = 8'h00;
        end else begin
            if (rd) begin
                if (addr < 4'd6)
                    m_rdata = m_port[addr[2:0]] | ext_pull[addr*8 +: 8];
                else if (addr == 4'd6)
                    m_rdata = {5'b0, pend};
                else if (addr >= 4'd8 && addr <= 4'd10 && m_ctl[7:6] == 2'd3)
                    m_rdata = id_mem[addr - 4'd8];
                else
                    m_rdata = 8'h00;
            end
            if (wr) begin
                if (addr < 4'd6) begin
                    if (!m_ctl[addr[2:0]]) m_port[addr[2:0]] = wdata;
                end else if (addr == 4'd7) begin
                    m_ctl = wdata;
                end else if (addr >= 4'd8 && addr <= 4'd10) begin
                    if (m_ctl[7:6] == 2'd1) m_pol[addr - 4'd8] = wdata;
                    if (m_ctl[7:6] == 2'd2) m_en[addr - 4'd8]  = wdata;
                end
            end
        end
    end

    task automatic note(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        if (rst_n && !done) begin
            logic [47:0] mflat;
            logic [23:0] mpol, men;
            logic        in_bank, e_wr, e_rd;
            #2;
            for (int i = 0; i < 6; i++) mflat[i*8 +: 8] = m_port[i];
            for (int i = 0; i < 3; i++) begin mpol[i*8 +: 8] = m_pol[i]; men[i*8 +: 8] = m_en[i]; end
            in_bank = addr >= 4'd8 && addr <= 4'd10;
            e_wr = wr && in_bank && m_ctl[7:6] == 2'd3;
            e_rd = rd && in_bank && m_ctl[7:6] == 2'd3;
            note("R2 model drive", 64'(pull_low), 64'(mflat));
            note("R6 model pol/en", {16'h0, pol, en}, {16'h0, mpol, men});
            note("R9 model rdata", 64'(rdata), 64'(m_rdata));
            note("R7 model strobes", {62'h0, id_wr, id_rd}, {62'h0, e_wr, e_rd});
            if (e_wr || e_rd) note("R7 model sel", 64'(id_sel), 64'(addr - 4'd8));
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            nerrors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_up();
        end
    end

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        #1;
    endtask

    task automatic do_rd(input logic [3:0] a);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        note("R1 drive", 64'(pull_low), 64'h0);
        note("R1 pol", 64'(pol), 64'h0);
        note("R1 en", 64'(en), 64'h0);
        note("R1 rdata", 64'(rdata), 64'h0);
        rst_n = 1'b1;
        do_rd(4'h0);
        note("R1 port0 released", 64'(rdata), 64'h0);

        // R2 port writes
        do_wr(4'h0, 8'hA5);
        note("R2 port0", 64'(pull_low[7:0]), 64'hA5);
        do_wr(4'h5, 8'h3C);
        note("R2 port5", 64'(pull_low[47:40]), 64'h3C);

        // R3 inverted pin read
        ext_pull[7:0] = 8'h0F;
        do_rd(4'h0);
        note("R3 port0 read", 64'(rdata), 64'hAF);
        ext_pull = '0;
        do_rd(4'h5);
        note("R3 port5 read", 64'(rdata), 64'h3C);

        // R4 lock
        do_wr(4'h7, 8'h02);
        do_wr(4'h1, 8'hFF);
        note("R4 locked write", 64'(pull_low[15:8]), 64'h00);
        ext_pull[15:8] = 8'h30;
        do_rd(4'h1);
        note("R4 locked read", 64'(rdata), 64'h30);
        ext_pull = '0;
        do_wr(4'h7, 8'h00);
        do_wr(4'h1, 8'h81);
        note("R4 unlocked write", 64'(pull_low[15:8]), 64'h81);

        // R5 pending summary
        pend = 3'b101;
        do_rd(4'h6);
        note("R5 pend read", 64'(rdata), 64'h05);
        do_wr(4'h6, 8'hFF);
        do_rd(4'h6);
        note("R5 pend after write", 64'(rdata), 64'h05);
        note("R5 drive untouched", 64'(pull_low), 64'h3C00000081A5);

        // R6 polarity and enable pages
        do_wr(4'h7, 8'h40);
        do_wr(4'h9, 8'h3C);
        note("R6 pol byte1", 64'(pol), 64'h003C00);
        note("R6 en untouched", 64'(en), 64'h0);
        do_rd(4'h9);
        note("R6 pol reads zero", 64'(rdata), 64'h0);
        do_wr(4'h7, 8'h80);
        do_wr(4'h8, 8'h11);
        note("R6 en byte0", 64'(en), 64'h000011);
        note("R6 pol kept", 64'(pol), 64'h003C00);
        do_rd(4'h8);
        note("R6 en reads zero", 64'(rdata), 64'h0);

        // R7 event-ID sideband
        do_wr(4'h7, 8'hC0);
        do_wr(4'hA, 8'h77);
        note("R7 id write", 64'(id_mem[2]), 64'h77);
        do_rd(4'hA);
        note("R7 id read", 64'(rdata), 64'h77);

        // R8 ignored and write-only locations
        do_wr(4'h7, 8'h00);
        do_wr(4'h8, 8'hFF);
        note("R8 page0 pol", 64'(pol), 64'h003C00);
        note("R8 page0 en", 64'(en), 64'h000011);
        do_rd(4'h8);
        note("R8 page0 read", 64'(rdata), 64'h0);
        do_rd(4'h7);
        note("R8 ctl read", 64'(rdata), 64'h0);
        do_wr(4'hF, 8'hFF);
        do_rd(4'hF);
        note("R8 unmapped read", 64'(rdata), 64'h0);
        note("R8 unmapped write", 64'(pull_low), 64'h3C00000081A5);

        // R9 read data holds between reads
        do_rd(4'h0);
        note("R9 read", 64'(rdata), 64'hA5);
        ext_pull[7:0] = 8'hFF;
        repeat (3) @(negedge clk);
        note("R9 hold", 64'(rdata), 64'hA5);
        ext_pull = '0;

        // mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a;
            logic [7:0] d;
            a = 4'($urandom_range(0, 15));
            d = 8'($urandom);
            if (a == 4'h7 && ($urandom_range(0, 3) != 0)) d[5:0] = 6'h00;
            ext_pull = {$urandom, $urandom};
            pend = 3'($urandom);
            if ($urandom_range(0, 1) == 0) do_wr(a, d);
            else                           do_rd(a);
        end
        @(negedge clk);
        finish_up();
    end
endmodule